// File: doc/BRIEF.md
# Supervisory reset pulse generator

This block drives the processor reset of a chip. It watches two reset causes: a supply-low flag that an analog comparator has already turned into a logic level, and an active-low pushbutton or logic manual-reset line. While either cause is present the reset is held. When the last cause goes away, the reset is stretched by a fixed number of millisecond ticks and then released. A fresh cause during the stretch throws away the count so far and starts a full new delay.

Because the delay always runs to its full length, a manual-reset pulse of any length produces a full-length reset. This also debounces a mechanical switch. The reset is driven in both polarities. A single-cycle release strobe tells downstream logic, such as a watchdog timer, that the processor has just come out of reset.

Top module: `supv_reset_gen`

## Requirements
- R1: While `supply_low_i` is 1, both reset outputs are asserted (`rst_o`=1, `rst_n_o`=0) from the next clock edge on. The delay count stays at zero for as long as the flag is high.
- R2: `man_rst_n_i` passes through a two-flop synchronizer. A low level sampled on one edge asserts reset at the edge two clocks later, and the reset holds while the synchronized level stays low.
- R3: Once no cause is present, reset releases on the clock edge at which the `DELAY_TICKS`-th `ms_tick_i` pulse is sampled (default 200). It never releases on an edge without a tick.
- R4: A cause that appears during the stretch clears the count. Release then needs a full `DELAY_TICKS` ticks counted after the cause is gone.
- R5: A manual-reset low level sampled on only one clock edge still produces a full-length reset of `DELAY_TICKS` ticks.
- R6: `rst_n_o` is always the complement of `rst_o`.
- R7: While `por_n_i` is 0, the block is in the asserted state (`rst_o`=1, `rel_o`=0) with its count cleared. After `por_n_i` rises, release needs a full `DELAY_TICKS` ticks.
- R8: `rel_o` is high for exactly one clock cycle, the cycle in which `rst_o` has just fallen, and is low at all other times.
- R9: After release, further ticks have no effect: the counter saturates, and the reset stays released until a new cause appears.
- R10: A tick sampled on the same edge as a cause is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n_i | input | 1 | Asynchronous active-low power-on reset of the logic |
| supply_low_i | input | 1 | Digitized supply-below-threshold flag, synchronous to `clk` |
| man_rst_n_i | input | 1 | Asynchronous active-low manual reset request |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| rst_o | output | 1 | Active-high processor reset |
| rst_n_o | output | 1 | Active-low processor reset |
| rel_o | output | 1 | One-cycle strobe when reset releases |

## Verification
The assertions take for granted three things about the inputs:
- `supply_low_i` is already synchronous to `clk`.
- `ms_tick_i` is a single-cycle strobe.
- `por_n_i` is only driven away from the active edge.

The stimulus drives every input just after a falling clock edge. It generates ticks as isolated one-cycle pulses. Manual-reset pulses are made as short as one sampled cycle, and causes are placed mid-stretch and on a tick edge, so that the restart and the tick-versus-cause corner cases are exercised.

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int DELAY_TICKS = 200
) (
  input  logic clk,
  input  logic por_n_i,
  input  logic supply_low_i,
  input  logic man_rst_n_i,
  input  logic ms_tick_i,
  output logic rst_o,
  output logic rst_n_o,
  output logic rel_o
);

  localparam int CNT_W = $clog2(DELAY_TICKS + 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(DELAY_TICKS);

  logic             mr_s1, mr_s2;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             cause, done_nx;

  always_ff @(posedge clk or negedge por_n_i)
    if (!por_n_i) begin
      mr_s1 <= 1'b1;
      mr_s2 <= 1'b1;
    end else begin
      mr_s1 <= man_rst_n_i;
      mr_s2 <= mr_s1;
    end

  assign cause   = supply_low_i | ~mr_s2;
  assign cnt_nx  = cause ? '0 :
                   (ms_tick_i && cnt != TERM) ? cnt + CNT_W'(1) : cnt;
  assign done_nx = (cnt_nx == TERM);

  always_ff @(posedge clk or negedge por_n_i)
    if (!por_n_i) begin
      cnt     <= '0;
      rst_o   <= 1'b1;
      rst_n_o <= 1'b0;
      rel_o   <= 1'b0;
    end else begin
      cnt     <= cnt_nx;
      rst_o   <= ~done_nx;
      rst_n_o <= done_nx;
      rel_o   <= rst_o & done_nx;
    end

  p_supply_hold_r1: assert property (@(posedge clk) disable iff (!por_n_i)
    supply_low_i |=> (rst_o && cnt == '0));

  p_manual_hold_r2: assert property (@(posedge clk) disable iff (!por_n_i)
    !mr_s2 |=> rst_o);

  p_release_on_tick_r3: assert property (@(posedge clk) disable iff (!por_n_i)
    $fell(rst_o) |-> $past(ms_tick_i));

  p_restart_r4: assert property (@(posedge clk) disable iff (!por_n_i)
    cause |=> (cnt == '0));

  p_complement_r6: assert property (@(posedge clk) disable iff (!por_n_i)
    rst_n_o == !rst_o);

  p_strobe_fall_r8: assert property (@(posedge clk) disable iff (!por_n_i)
    rel_o |-> $fell(rst_o));

  p_fall_strobe_r8: assert property (@(posedge clk) disable iff (!por_n_i)
    $fell(rst_o) |-> rel_o);

  p_stay_released_r9: assert property (@(posedge clk) disable iff (!por_n_i)
    (!rst_o && !cause) |=> !rst_o);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!por_n_i)
    cnt <= TERM);

endmodule

// File: tb/supv_reset_gen_tb_top.sv
module supv_reset_gen_tb_top;
  localparam int D = 200;

  logic clk = 1'b0;
  logic por_n = 1'b0, supply_low = 1'b0, man_n = 1'b1;
  logic tick_auto = 1'b0, auto_t = 1'b0, man_t = 1'b0;
  logic ms_tick;
  logic rst, rst_n, rel;

  assign ms_tick = tick_auto ? auto_t : man_t;
  always #2 clk = ~clk;

  supv_reset_gen #(.DELAY_TICKS(D)) dut_i (
    .clk(clk), .por_n_i(por_n), .supply_low_i(supply_low),
    .man_rst_n_i(man_n), .ms_tick_i(ms_tick),
    .rst_o(rst), .rst_n_o(rst_n), .rel_o(rel));

  int checks = 0, fails = 0, cycles = 0, div = 0;
  string cur_req = "R7";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // tick generator: one-cycle pulse every 3 clocks
  always @(negedge clk) begin
    div = (div == 2) ? 0 : div + 1;
    auto_t <= (div == 2);
  end

  // behavioural reference model
  bit mr_hist[$] = '{1'b1, 1'b1};
  int m_cnt = 0, tsc = 0;
  bit m_hi = 1'b1, m_rel = 1'b0, cz;
  always @(posedge clk) begin
    cycles++;
    if (!por_n) begin
      mr_hist = '{1'b1, 1'b1};
      m_cnt = 0; m_hi = 1'b1; m_rel = 1'b0; tsc = 0;
    end else begin
      cz = supply_low || !mr_hist[0];
      if (cz) m_cnt = 0;
      else if (ms_tick && m_cnt < D) m_cnt++;
      if (cz) tsc = 0;
      else if (ms_tick) tsc++;
      m_rel = m_hi && (m_cnt == D);
      m_hi = (m_cnt != D);
      void'(mr_hist.pop_front());
      mr_hist.push_back(man_n);
    end
  end

  // per-cycle comparison and release bookkeeping
  bit prev_hi = 1'b1;
  int rel_seen = 0, tsc_at_fall = -1;
  always @(negedge clk) begin
    if (por_n) begin
      check(rst == m_hi, cur_req, rst, m_hi);
      check(rel == m_rel, "R8", rel, m_rel);
      check(rst_n == !rst, "R6", rst_n, !rst);
      if (rel) rel_seen++;
      if (prev_hi && !rst) tsc_at_fall = tsc;
    end
    prev_hi = rst;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_release(input string req);
    int guard = 0;
    tsc_at_fall = -1;
    rel_seen = 0;
    while (rst && guard < 5000) begin @(negedge clk); guard++; end
    cyc(3);
    check(tsc_at_fall == D, req, tsc_at_fall, D);
    check(rel_seen == 1, "R8", rel_seen, 1);
  endtask

  initial begin
    cyc(3);
    check(rst == 1 && rst_n == 0 && rel == 0, "R7", rst, 1);
    por_n = 1'b1; tick_auto = 1'b1;
    expect_release("R7");

    cur_req = "R1"; supply_low = 1'b1;
    cyc(60);
    check(rst == 1, "R1", rst, 1);
    supply_low = 1'b0; cur_req = "R3";
    expect_release("R3");

    cur_req = "R2"; man_n = 1'b0;
    cyc(30);
    check(rst == 1, "R2", rst, 1);
    man_n = 1'b1; cur_req = "R3";
    expect_release("R2");

    cur_req = "R5"; man_n = 1'b0;
    cyc(1);
    man_n = 1'b1;
    cyc(4);
    check(rst == 1, "R5", rst, 1);
    expect_release("R5");

    cur_req = "R4"; supply_low = 1'b1;
    cyc(1);
    supply_low = 1'b0;
    cyc(300);
    check(rst == 1, "R4", rst, 1);
    supply_low = 1'b1;
    cyc(1);
    supply_low = 1'b0;
    expect_release("R4");

    cur_req = "R10"; tick_auto = 1'b0;
    cyc(5);
    supply_low = 1'b1; man_t = 1'b1;
    cyc(1);
    supply_low = 1'b0; man_t = 1'b0;
    cyc(2);
    tick_auto = 1'b1;
    expect_release("R10");

    cur_req = "R9";
    cyc(900);
    check(rst == 0 && rst_n == 1, "R9", rst, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #600000;
    check(1'b0, "watchdog", cycles, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule